// File: doc/BRIEF.md
# External Data Memory Stretch Timer

This block times one access to external data memory for an 8051-style controller. An access is requested by a one-clock start pulse, together with a direction bit (read or write) and a 3-bit stretch setting. The setting fixes how many machine cycles (four clocks each) the access occupies and how long the active-low read or write strobe is held. The CPU sequencer holds off its next external access while `busy` is high and moves on after the `done` pulse.

The strobe width does not grow linearly with the setting. Setting 0 gives a short two-clock strobe inside a two-cycle access. Each higher setting adds one machine cycle to the access and four clocks to the strobe. The strobe always begins one machine cycle after the access starts. The rest of the access is spent with both strobes high, so address and data have time to set up and to hold around the strobe. Bus multiplexing, address latching and the sequencer itself are outside this block.

Top module: `ext_mem_stretch`

## Requirements
- R1: While `rst_n` is low, `rd_n` and `wr_n` are 1 and `busy` and `done` are 0. Asserting `rst_n` low in the middle of an access forces this state at once, without waiting for a clock.
- R2: A start pulse taken while idle raises `busy` on the next clock. `busy` then stays high for exactly 4 × (S + 2) clocks, where S is the setting 0..7.
- R3: The active strobe is low for exactly 2 clocks when S = 0, and for 4 × S clocks when S is 1..7.
- R4: The strobe goes low on the fifth clock of `busy`, which is clock index 4 when the first busy clock is index 0. It stays low for a single unbroken run.
- R5: When `acc_write` is 0 only `rd_n` pulses, and when it is 1 only `wr_n` pulses. The two strobes are never low on the same clock.
- R6: `done` is high for exactly one clock, on the last clock of `busy`, and on no other clock.
- R7: The setting and the direction are sampled on the start clock. Changing `stretch_code` or `acc_write` during an access changes neither the strobe nor the length of that access.
- R8: A start pulse that arrives while `busy` is high is ignored. This holds on the `done` clock too: the access ends on schedule and no new access follows.
- R9: While idle, both strobes stay high and `done` stays low.
- R10: A start pulse given on the clock right after the `done` clock begins a new access with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc_start | input | 1 | One-clock request to begin an access |
| acc_write | input | 1 | Direction: 0 = read, 1 = write. Sampled with `acc_start` |
| stretch_code | input | 3 | Stretch setting S (0..7). Sampled with `acc_start` |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| busy | output | 1 | High for every clock of an access |
| done | output | 1 | One-clock pulse on the last clock of an access |

## Verification
On every clock, the assertions check the properties that concern single cycles. The two strobes are never low together. No strobe and no `done` appears while idle. `done` falls only inside an access and ends it. `busy` only drops on the `done` clock and only rises after a start pulse. The exact strobe width and its position for each of the eight settings, the total access length, the sampling of setting and direction at start, and the handling of start pulses during an access can only be shown by the bench. Its scenarios walk every clock of each access and compare the outputs against the width and length formulas.

// File: rtl/ext_stretch_pkg.sv
package ext_stretch_pkg;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } acc_dir_e;

  // Total clocks of an access for setting 'code'
  function automatic int total_clks(int code, int cpc, int min_cyc);
    return cpc * (code + min_cyc);
  endfunction

  // Strobe low time in clocks for setting 'code'
  function automatic int strobe_clks(int code, int cpc, int short_w);
    return (code == 0) ? short_w : cpc * code;
  endfunction

endpackage

// File: rtl/ext_stretch_rst_sync.sv
module ext_stretch_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_int_n = sync_q;

endmodule

// File: rtl/ext_stretch_decode.sv
module ext_stretch_decode
  import ext_stretch_pkg::*;
#(
  parameter int CODE_W  = 3,
  parameter int CPC     = 4,
  parameter int MIN_CYC = 2,
  parameter int SHORT_W = 2,
  parameter int CNT_W   = 6
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  last_cnt,
  output logic [CNT_W-1:0]  strobe_w
);

  localparam int NCODES = 1 << CODE_W;

  logic [CNT_W-1:0] last_lut  [NCODES];
  logic [CNT_W-1:0] width_lut [NCODES];

  for (genvar g = 0; g < NCODES; g++) begin : g_lut
    assign last_lut[g]  = CNT_W'(total_clks(g, CPC, MIN_CYC) - 1);
    assign width_lut[g] = CNT_W'(strobe_clks(g, CPC, SHORT_W));
  end

  assign last_cnt = last_lut[code];
  assign strobe_w = width_lut[code];

endmodule

// File: rtl/ext_stretch_counter.sv
module ext_stretch_counter
  import ext_stretch_pkg::*;
#(
  parameter int               CNT_W     = 6,
  parameter logic [CNT_W-1:0] RST_LAST  = '0,
  parameter logic [CNT_W-1:0] RST_WIDTH = '0
) (
  input  logic             clk,
  input  logic             rst_int_n,
  input  logic             start,
  input  acc_dir_e         dir_in,
  input  logic [CNT_W-1:0] last_in,
  input  logic [CNT_W-1:0] width_in,
  output logic             busy_q,
  output logic             busy_d,
  output logic [CNT_W-1:0] cnt_d,
  output logic [CNT_W-1:0] last_d,
  output logic [CNT_W-1:0] width_d,
  output acc_dir_e         dir_d
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_q;
  logic [CNT_W-1:0] width_q;
  acc_dir_e         dir_q;
  logic             accept;
  logic             cfg_en;
  logic             run_en;

  // Next state
  always_comb begin
    accept  = start && !busy_q;
    cfg_en  = accept;
    run_en  = accept || busy_q;
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    last_d  = cfg_en ? last_in  : last_q;
    width_d = cfg_en ? width_in : width_q;
    dir_d   = cfg_en ? dir_in   : dir_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == last_q) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      last_q  <= RST_LAST;
      width_q <= RST_WIDTH;
      dir_q   <= DIR_READ;
    end else begin
      if (run_en) begin
        busy_q <= busy_d;
        cnt_q  <= cnt_d;
      end
      if (cfg_en) begin
        last_q  <= last_d;
        width_q <= width_d;
        dir_q   <= dir_d;
      end
    end
  end

endmodule

// File: rtl/ext_stretch_strobe.sv
module ext_stretch_strobe
  import ext_stretch_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int LEAD_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst_int_n,
  input  logic             busy_d,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [CNT_W-1:0] last_d,
  input  logic [CNT_W-1:0] width_d,
  input  acc_dir_e         dir_d,
  output logic             rd_n,
  output logic             wr_n,
  output logic             done
);

  localparam logic [CNT_W:0] LEAD_V = (CNT_W+1)'(LEAD_CLKS);

  logic           in_win;
  logic [CNT_W:0] win_end;
  logic           rd_n_d;
  logic           wr_n_d;
  logic           done_d;
  logic           rd_n_q;
  logic           wr_n_q;
  logic           done_q;

  always_comb begin
    win_end = {1'b0, width_d} + LEAD_V;
    in_win  = busy_d && ({1'b0, cnt_d} >= LEAD_V) && ({1'b0, cnt_d} < win_end);
    rd_n_d  = !(in_win && (dir_d == DIR_READ));
    wr_n_d  = !(in_win && (dir_d == DIR_WRITE));
    done_d  = busy_d && (cnt_d == last_d);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_n_q <= 1'b1;
      wr_n_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      rd_n_q <= rd_n_d;
      wr_n_q <= wr_n_d;
      done_q <= done_d;
    end
  end

  assign rd_n = rd_n_q;
  assign wr_n = wr_n_q;
  assign done = done_q;

endmodule

// File: rtl/ext_mem_stretch.sv
module ext_mem_stretch
  import ext_stretch_pkg::*;
#(
  parameter int CODE_W       = 3,
  parameter int CPC          = 4,
  parameter int MIN_CYC      = 2,
  parameter int SHORT_W      = 2,
  parameter int LEAD_CLKS    = 4,
  parameter int DEFAULT_CODE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_start,
  input  logic              acc_write,
  input  logic [CODE_W-1:0] stretch_code,
  output logic              rd_n,
  output logic              wr_n,
  output logic              busy,
  output logic              done
);

  localparam int NCODES    = 1 << CODE_W;
  localparam int MAX_TOTAL = total_clks(NCODES - 1, CPC, MIN_CYC);
  localparam int CNT_W     = $clog2(MAX_TOTAL);
  localparam logic [CNT_W-1:0] RST_LAST  =
    CNT_W'(total_clks(DEFAULT_CODE, CPC, MIN_CYC) - 1);
  localparam logic [CNT_W-1:0] RST_WIDTH =
    CNT_W'(strobe_clks(DEFAULT_CODE, CPC, SHORT_W));

  logic             rst_int_n;
  logic [CNT_W-1:0] dec_last;
  logic [CNT_W-1:0] dec_width;
  logic             busy_q;
  logic             busy_d;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last_d;
  logic [CNT_W-1:0] width_d;
  acc_dir_e         dir_d;

  ext_stretch_rst_sync rst_sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  ext_stretch_decode #(
    .CODE_W  (CODE_W),
    .CPC     (CPC),
    .MIN_CYC (MIN_CYC),
    .SHORT_W (SHORT_W),
    .CNT_W   (CNT_W)
  ) decode_i (
    .code     (stretch_code),
    .last_cnt (dec_last),
    .strobe_w (dec_width)
  );

  ext_stretch_counter #(
    .CNT_W     (CNT_W),
    .RST_LAST  (RST_LAST),
    .RST_WIDTH (RST_WIDTH)
  ) counter_i (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .start     (acc_start),
    .dir_in    (acc_dir_e'(acc_write)),
    .last_in   (dec_last),
    .width_in  (dec_width),
    .busy_q    (busy_q),
    .busy_d    (busy_d),
    .cnt_d     (cnt_d),
    .last_d    (last_d),
    .width_d   (width_d),
    .dir_d     (dir_d)
  );

  ext_stretch_strobe #(
    .CNT_W     (CNT_W),
    .LEAD_CLKS (LEAD_CLKS)
  ) strobe_i (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .busy_d    (busy_d),
    .cnt_d     (cnt_d),
    .last_d    (last_d),
    .width_d   (width_d),
    .dir_d     (dir_d),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .done      (done)
  );

  assign busy = busy_q;

endmodule

// File: rtl/ext_stretch_chk.sv
module ext_stretch_chk (
  input logic clk,
  input logic rst_n,
  input logic acc_start,
  input logic rd_n,
  input logic wr_n,
  input logic busy,
  input logic done
);

  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_done_inside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_done_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_n && wr_n && !done));

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(acc_start));

endmodule

bind ext_mem_stretch ext_stretch_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_start (acc_start),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .busy      (busy),
  .done      (done)
);

// File: tb/ext_mem_stretch_tb.sv
`timescale 1ns/1ps
module ext_mem_stretch_tb_top;

  logic       clk;
  logic       rst_n;
  logic       acc_start;
  logic       acc_write;
  logic [2:0] stretch_code;
  logic       rd_n;
  logic       wr_n;
  logic       busy;
  logic       done;

  int n_vec;
  int n_err;
  bit finished;

  ext_mem_stretch dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_start    (acc_start),
    .acc_write    (acc_write),
    .stretch_code (stretch_code),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .busy         (busy),
    .done         (done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_total(int s);
    return 4 * (s + 2);
  endfunction

  function automatic int exp_width(int s);
    return (s == 0) ? 2 : 4 * s;
  endfunction

  // Runs one access from an idle negedge and checks every clock.
  // alt_en: change setting/direction at clock 1. poke_k: clock index on
  // which a further start pulse is driven (-1 for none).
  task automatic run_access(input int s, input bit wr, input bit alt_en,
                            input int alt_s, input int poke_k);
    int total;
    int width;
    int low_cnt;
    total   = exp_total(s);
    width   = exp_width(s);
    low_cnt = 0;
    acc_start    = 1'b1;
    acc_write    = wr;
    stretch_code = 3'(s);
    for (int k = 0; k < total; k++) begin
      bit strobe;
      @(negedge clk);
      strobe = (k >= 4) && (k < 4 + width);
      chk("R2 busy", busy, 1);
      chk("R4 R3 strobe", wr ? wr_n : rd_n, strobe ? 0 : 1);
      chk("R5 other strobe", wr ? rd_n : wr_n, 1);
      chk("R6 done", done, (k == total - 1) ? 1 : 0);
      if ((wr ? wr_n : rd_n) == 1'b0) low_cnt++;
      acc_start = (k == poke_k);
      if (alt_en && k == 1) begin
        stretch_code = 3'(alt_s);
        acc_write    = ~wr;
      end
    end
    @(negedge clk);
    acc_start = 1'b0;
    chk("R3 width", low_cnt, width);
    chk("R2 end busy", busy, 0);
    chk("R9 idle rd", rd_n, 1);
    chk("R9 idle wr", wr_n, 1);
    chk("R9 idle done", done, 0);
  endtask

  task automatic t_reset();
    acc_start    = 1'b0;
    acc_write    = 1'b0;
    stretch_code = 3'd1;
    rst_n        = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 rd", rd_n, 1);
    chk("R1 wr", wr_n, 1);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 idle busy", busy, 0);
  endtask

  task automatic t_all_codes();
    for (int s = 0; s < 8; s++) begin
      run_access(s, 1'b0, 1'b0, 0, -1);
      run_access(s, 1'b1, 1'b0, 0, -1);
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic t_mid_change();
    // R7: short setting changed to longest, direction flipped
    run_access(0, 1'b0, 1'b1, 7, -1);
    run_access(7, 1'b1, 1'b1, 0, -1);
    run_access(1, 1'b0, 1'b1, 5, -1);
  endtask

  task automatic t_busy_start();
    // R8: extra pulses mid access and on the done clock
    run_access(2, 1'b1, 1'b0, 0, 3);
    run_access(0, 1'b0, 1'b0, 0, exp_total(0) - 1);
    repeat (3) @(negedge clk);
    chk("R8 no follow-on access", busy, 0);
  endtask

  task automatic t_back_to_back();
    // R10: a new start right after the done clock
    run_access(1, 1'b0, 1'b0, 0, -1);
    run_access(3, 1'b1, 1'b0, 0, -1);
    run_access(0, 1'b0, 1'b0, 0, -1);
  endtask

  task automatic t_reset_mid();
    acc_start    = 1'b1;
    acc_write    = 1'b0;
    stretch_code = 3'd6;
    @(negedge clk);
    acc_start = 1'b0;
    repeat (6) @(negedge clk);
    chk("R1 strobe before reset", rd_n, 0);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async rd", rd_n, 1);
    chk("R1 async busy", busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_access(4, 1'b1, 1'b0, 0, -1);
  endtask

  initial begin
    n_vec    = 0;
    n_err    = 0;
    finished = 1'b0;
    @(negedge clk);
    t_reset();
    t_all_codes();
    t_mid_change();
    t_busy_start();
    t_back_to_back();
    t_reset_mid();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

endmodule